// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath slice that turns two W-bit operands, a carry input, a 4-bit selection code and a 2-bit shift-type code into one W-bit result, a carry-out and a shift-left overflow flag. Every result bit is picked by one four-way multiplexer per bit position. Its four inputs are an adder bit, a logic-gate bit, the left neighbour of the operand bit (shift right) and the right neighbour (shift left). All slices share the same two upper selection lines.

The unit has no storage. Source registers drive the operands, and a destination register captures the result at the end of the same clock period. Two's-complement negation of B is obtained by presenting A = 0 with the subtract code. One's complement of A comes from the logic stage.

Top module: `alsu_core`

## Requirements
- R1: sel_i[3:2] picks the stage: 00 arithmetic, 01 logic, 10 shift right by one, 11 shift left by one.
- R2: In the arithmetic stage, res_o = (A + X + cin_i) mod 2^W. X is chosen by sel_i[1:0]: 00 gives B, 01 gives ~B, 10 gives all zeros, 11 gives all ones. This covers add, add with carry, subtract (01 with cin 1), transfer, increment and decrement.
- R3: cout_o is the adder carry out of bit W-1 in the arithmetic stage, and is 0 in every other stage.
- R4: In the logic stage, sel_i[1:0] selects 00 A AND B, 01 A OR B, 10 A XOR B, 11 NOT A. cin_i has no effect there.
- R5: In shift right, res_o[i] = A[i+1] for i < W-1. res_o[W-1] depends on shtype_i: 00 gives 0, 01 gives A[0] (rotate), 10 gives A[W-1] (arithmetic, sign kept), 11 gives 0.
- R6: In shift left, res_o[i] = A[i-1] for i > 0. res_o[0] is A[W-1] when shtype_i = 01 (rotate) and 0 for every other type.
- R7: vshl_o = A[W-1] XOR A[W-2] of the unshifted operand when the stage is shift left and shtype_i = 10. In every other case vshl_o is 0.
- R8: Outputs depend only on the present inputs. A change of inputs appears on the outputs within the same clock period, with no clock edge in between, and all-zero inputs give all-zero outputs.
- R9: shtype_i has no effect on any output in the arithmetic and logic stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand, also the shifted operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Adder carry input |
| sel_i | input | 4 | Stage (bits 3:2) and sub-operation (bits 1:0) |
| shtype_i | input | 2 | Serial fill for shifts: logical, rotate, arithmetic, spare |
| res_o | output | W | Result |
| cout_o | output | 1 | Adder carry out, 0 outside the arithmetic stage |
| vshl_o | output | 1 | Arithmetic shift-left overflow flag |

## Verification
The hardest cases are the carry rippling across all W slices and the end bits of the shifts. A carry reaches the top only with operands such as all ones plus a carry-in, or B = 0 with the inverted-B subtract. The end bits are fed by serial inputs that differ between the three shift types. The stimulus drives directed vectors for these cases: FFFF+0+1, 0-1, 8000 and 4000 under every shift type, and the overflow pairs 01/10 in the two top bits. A stream of pseudo-random vectors then sweeps every selection and shift-type code while the shift type also toggles under arithmetic and logic codes.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        STG_ARITH = 2'b00,
        STG_LOGIC = 2'b01,
        STG_SHR   = 2'b10,
        STG_SHL   = 2'b11
    } stage_e;

    typedef enum logic [1:0] {
        SHT_LOGICAL = 2'b00,
        SHT_ROTATE  = 2'b01,
        SHT_ARITH   = 2'b10,
        SHT_SPARE   = 2'b11
    } shtype_e;

    typedef enum logic [1:0] {
        XSEL_B    = 2'b00,
        XSEL_NOTB = 2'b01,
        XSEL_ZERO = 2'b10,
        XSEL_ONES = 2'b11
    } xsel_e;

    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [1:0]   xsel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W-1:0] x_side;
    logic [W:0]   carry;

    always_comb begin
        unique case (xsel_e'(xsel_i))
            XSEL_B:    x_side = b_i;
            XSEL_NOTB: x_side = ~b_i;
            XSEL_ZERO: x_side = '0;
            XSEL_ONES: x_side = '1;
            default:   x_side = '0;
        endcase
    end

    assign carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic half;
        assign half       = a_i[i] ^ x_side[i];
        assign sum_o[i]   = half ^ carry[i];
        assign carry[i+1] = (a_i[i] & x_side[i]) | (carry[i] & half);
    end

    assign cout_o = carry[W];

    always_comb begin
        if (xsel_e'(xsel_i) == XSEL_ZERO && !cin_i)
            AST_TRANSFER_NO_CARRY: assert (cout_o == 1'b0) else $error("transfer produced carry"); // R3
    end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   lop_i,
    output logic [W-1:0] res_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (lop_e'(lop_i))
                LOP_AND:  res_o[i] = a_i[i] & b_i[i];
                LOP_OR:   res_o[i] = a_i[i] | b_i[i];
                LOP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                LOP_NOTA: res_o[i] = ~a_i[i];
                default:  res_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alsu_serial.sv
module alsu_serial
    import alsu_pkg::*;
(
    input  logic       a_msb_i,
    input  logic       a_lsb_i,
    input  logic [1:0] shtype_i,
    output logic       fill_top_o,
    output logic       fill_bot_o
);

    always_comb begin
        unique case (shtype_e'(shtype_i))
            SHT_ROTATE: begin
                fill_top_o = a_lsb_i;
                fill_bot_o = a_msb_i;
            end
            SHT_ARITH: begin
                fill_top_o = a_msb_i;
                fill_bot_o = 1'b0;
            end
            default: begin
                fill_top_o = 1'b0;
                fill_bot_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alsu_core.sv
module alsu_core
    import alsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [3:0]   sel_i,
    input  logic [1:0]   shtype_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         vshl_o
);

    localparam int MSB = W - 1;

    stage_e       stage;
    logic [W-1:0] arith_res;
    logic         arith_cout;
    logic [W-1:0] logic_res;
    logic         fill_top;
    logic         fill_bot;

    assign stage = stage_e'(sel_i[3:2]);

    alsu_arith #(.W(W)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .xsel_i (sel_i[1:0]),
        .sum_o  (arith_res),
        .cout_o (arith_cout)
    );

    alsu_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .lop_i (sel_i[1:0]),
        .res_o (logic_res)
    );

    alsu_serial u_serial (
        .a_msb_i    (a_i[MSB]),
        .a_lsb_i    (a_i[0]),
        .shtype_i   (shtype_i),
        .fill_top_o (fill_top),
        .fill_bot_o (fill_bot)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic from_left;
        logic from_right;
        if (i == MSB) begin : g_top
            assign from_left = fill_top;
        end else begin : g_mid_l
            assign from_left = a_i[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_right = fill_bot;
        end else begin : g_mid_r
            assign from_right = a_i[i-1];
        end
        always_comb begin
            unique case (stage)
                STG_ARITH: res_o[i] = arith_res[i];
                STG_LOGIC: res_o[i] = logic_res[i];
                STG_SHR:   res_o[i] = from_left;
                STG_SHL:   res_o[i] = from_right;
                default:   res_o[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        cout_o = (stage == STG_ARITH) ? arith_cout : 1'b0;
        vshl_o = (stage == STG_SHL && shtype_e'(shtype_i) == SHT_ARITH)
                 ? (a_i[MSB] ^ a_i[MSB-1]) : 1'b0;
    end

    always_comb begin
        if (stage != STG_ARITH)
            AST_COUT_IDLE: assert (cout_o == 1'b0) else $error("carry outside arith"); // R3
        if (stage != STG_SHL)
            AST_VSHL_IDLE: assert (vshl_o == 1'b0) else $error("overflow outside shl"); // R7
        if (stage == STG_SHR && shtype_e'(shtype_i) == SHT_ARITH)
            AST_SHR_SIGN_KEPT: assert (res_o[MSB] == a_i[MSB]) else $error("sign lost"); // R5
        if (stage == STG_SHL && shtype_e'(shtype_i) != SHT_ROTATE)
            AST_SHL_ZERO_FILL: assert (res_o[0] == 1'b0) else $error("lsb not zero"); // R6
        if ((stage == STG_SHL || stage == STG_SHR) && shtype_e'(shtype_i) == SHT_ROTATE)
            AST_ROTATE_KEEPS_ONES: assert ($countones(res_o) == $countones(a_i)) else $error("rotate lost bit"); // R5
        if (stage == STG_LOGIC && lop_e'(sel_i[1:0]) == LOP_NOTA)
            AST_LOGIC_COMPLEMENT: assert (res_o == ~a_i) else $error("complement wrong"); // R4
    end

endmodule

// File: tb/alsu_core_tb_top.sv
module alsu_core_tb_top;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] res;
        logic         cout;
        logic         v;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cin_i = 1'b0;
    logic [3:0]   sel_i = 4'h0;
    logic [1:0]   shtype_i = 2'b00;
    logic [W-1:0] res_o;
    logic         cout_o;
    logic         vshl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    alsu_core #(.W(W)) dut_i (
        .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sel_i(sel_i),
        .shtype_i(shtype_i), .res_o(res_o), .cout_o(cout_o), .vshl_o(vshl_o)
    );

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic c, input logic [3:0] s, input logic [1:0] t);
        exp_t e;
        logic [W:0]   wide;
        logic [W-1:0] x;
        logic         fill;
        e.cout = 1'b0;
        e.v    = 1'b0;
        case (s[3:2])
            2'b00: begin
                case (s[1:0])
                    2'b00: x = b;
                    2'b01: x = ~b;
                    2'b10: x = '0;
                    default: x = '1;
                endcase
                wide   = {1'b0, a} + {1'b0, x} + {{W{1'b0}}, c};
                e.res  = wide[W-1:0];
                e.cout = wide[W];
                e.tag  = "R2/R3";
            end
            2'b01: begin
                case (s[1:0])
                    2'b00: e.res = a & b;
                    2'b01: e.res = a | b;
                    2'b10: e.res = a ^ b;
                    default: e.res = ~a;
                endcase
                e.tag = "R4";
            end
            2'b10: begin
                fill  = (t == 2'b01) ? a[0] : (t == 2'b10) ? a[W-1] : 1'b0;
                e.res = {fill, a[W-1:1]};
                e.tag = "R5";
            end
            default: begin
                fill  = (t == 2'b01) ? a[W-1] : 1'b0;
                e.res = {a[W-2:0], fill};
                e.v   = (t == 2'b10) ? (a[W-1] ^ a[W-2]) : 1'b0;
                e.tag = "R6/R7";
            end
        endcase
        return e;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                         input logic [3:0] s, input logic [1:0] t, input string req);
        exp_t e;
        @(negedge clk);
        a_i = a; b_i = b; cin_i = c; sel_i = s; shtype_i = t;
        e = model(a, b, c, s, t);
        e.tag = {req, " ", e.tag};
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (res_o !== e.res || cout_o !== e.cout || vshl_o !== e.v) begin
                errors++;
                $display("FAIL %s: res=%h cout=%b v=%b expected res=%h cout=%b v=%b",
                         e.tag, res_o, cout_o, vshl_o, e.res, e.cout, e.v);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: all-zero inputs give all-zero outputs, same period
        drive('0, '0, 1'b0, 4'b0000, 2'b00, "R8 zero");
        // R1 R2 R3 arithmetic corners
        drive(16'hFFFF, 16'h0000, 1'b1, 4'b0000, 2'b00, "R3 carry ripple");
        drive(16'h1234, 16'h1111, 1'b0, 4'b0000, 2'b00, "R2 add");
        drive(16'h1234, 16'h1111, 1'b1, 4'b0001, 2'b00, "R2 subtract");
        drive(16'h0000, 16'h0001, 1'b1, 4'b0001, 2'b00, "R2 negate");
        drive(16'h0005, 16'h0000, 1'b1, 4'b0001, 2'b00, "R3 sub B=0 carry");
        drive(16'hABCD, 16'h5555, 1'b0, 4'b0010, 2'b00, "R2 transfer");
        drive(16'hFFFF, 16'h5555, 1'b1, 4'b0010, 2'b00, "R2 increment wrap");
        drive(16'h0000, 16'h5555, 1'b0, 4'b0011, 2'b00, "R2 decrement wrap");
        // R4 logic
        for (int k = 0; k < 4; k++)
            drive(16'hF0CC, 16'hAA0F, 1'(k), 4'b0100 | 4'(k), 2'(k), "R4 logic op");
        // R5 R6 R7 shift ends under every type
        for (int t = 0; t < 4; t++) begin
            drive(16'h8001, '0, 1'b0, 4'b1000, 2'(t), "R5 shr ends");
            drive(16'h8001, '0, 1'b0, 4'b1100, 2'(t), "R6 shl ends");
            drive(16'h4000, '0, 1'b0, 4'b1100, 2'(t), "R7 overflow 01");
            drive(16'h8000, '0, 1'b0, 4'b1100, 2'(t), "R7 overflow 10");
            drive(16'hC000, '0, 1'b0, 4'b1100, 2'(t), "R7 no overflow 11");
        end
        // R9: shift type toggled under arithmetic and logic codes
        for (int t = 0; t < 4; t++) begin
            drive(16'h7FFF, 16'h0001, 1'b0, 4'b0000, 2'(t), "R9 arith shtype");
            drive(16'h7FFF, 16'h0F0F, 1'b0, 4'b0110, 2'(t), "R9 logic shtype");
        end
        // R1 sweep of every code with pseudo-random operands
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[15:0], r[31:16], r[0] ^ r[9], 4'(n % 16), 2'((n / 16) % 4), "R1 sweep");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule